// File: doc/BRIEF.md
# Power-Fail Reset and Write-Protect Supervisor

This block runs synchronously and watches two supply comparator flags that have already been digitized. One flag reports that the supply is above the write-protect trip point. The other reports that the supply is above the level at which the backup cell takes over. The block drives three things:

- a pull-low reset request for the processor;
- a write-protect signal that deselects the memory array;
- a connect request for the backup source.

Both flags pass through a two-flop synchronizer. Each flag must then hold a new value for a set number of clock cycles before the block accepts it. All time intervals are given as cycle counts. By default they are derived from the clock frequency parameter, so a bench can shorten them.

When the supply returns, two intervals start from the same moment. The reset request is held for about 200 ms. The write protection lifts after a shorter recovery interval of about 125 ms. If a fault arrives while either interval is running, both outputs are reasserted at once, and both intervals start again from zero on the next valid supply.

The backup source stays unusable after reset until the supply has been accepted as valid once. From then on it connects whenever the switchover flag is low. While protection is active, the block also gates the memory's select, write and output-drive strobes, so the array ignores the bus and leaves its data pins floating.

Top module: `pwr_supervisor`

## Requirements
- R1: After reset, rst_pull_o=1, wprot_o=1, bat_conn_o=0, and arr_ce_o, arr_we_o and arr_oe_o are all 0.
- R2: A new value on either raw supply flag is accepted only after the two synchronizer flops plus STABLE_CYC consecutive cycles of the same value. Acceptance lands on the (STABLE_CYC+2)th rising edge after the input changes. A pulse lasting STABLE_CYC-1 cycles has no effect on any output.
- R3: When a low trip flag is accepted, rst_pull_o and wprot_o both go to 1 in that same cycle.
- R4: After a high trip flag is accepted, rst_pull_o stays 1 for RST_CYC more rising edges and then goes to 0.
- R5: After a high trip flag is accepted, wprot_o stays 1 for REC_CYC more rising edges and then goes to 0. This interval is timed separately from R4.
- R6: While wprot_o=1, arr_ce_o, arr_we_o and arr_oe_o are 0 whatever the request inputs are.
- R7: While wprot_o=0, the gating is as follows, with all strobes active high:
  - arr_ce_o = mem_ce_i;
  - arr_we_o = mem_ce_i & mem_we_i;
  - arr_oe_o = mem_ce_i & mem_oe_i & ~mem_we_i.
- R8: A fault accepted while either interval is running clears both intervals. The next valid supply times the full RST_CYC and REC_CYC again.
- R9: Once a high trip flag has been accepted, backup stays armed until rst_ni. bat_conn_o is then 1 exactly while the accepted switchover flag is low.
- R10: Until the first accepted high trip flag, bat_conn_o stays 0 even while the switchover flag is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| vtrip_ok_i | input | 1 | Raw flag: supply above write-protect trip point |
| vsw_ok_i | input | 1 | Raw flag: supply above backup switchover level |
| mem_ce_i | input | 1 | Requested array select, active high |
| mem_we_i | input | 1 | Requested write strobe, active high |
| mem_oe_i | input | 1 | Requested output drive, active high |
| rst_pull_o | output | 1 | 1 pulls the open-drain reset line low; 0 releases it (the line is never driven high) |
| wprot_o | output | 1 | Write protect and deselect of the array |
| bat_conn_o | output | 1 | Connect backup source to the array |
| arr_ce_o | output | 1 | Gated array select |
| arr_we_o | output | 1 | Gated write strobe |
| arr_oe_o | output | 1 | Gated data output drive enable |

## Verification
The assertions assume the following about the inputs:
- the raw flags are asynchronous levels that can bounce;
- the RST_CYC, REC_CYC and STABLE_CYC counts are at least one;
- only the accepted trip flag arms the backup.

The stimulus changes every input at the falling clock edge. It keeps each supply level long enough to be accepted, except for a deliberate glitch that is exactly one cycle shorter than the stability window. It applies power-up, fault and recovery sequences in the order a real supply ramp would produce them, so the switchover flag is only low while the trip flag is also low.

// File: rtl/pwrsup_pkg.sv
package pwrsup_pkg;
  localparam int unsigned FLAG_N   = 2;
  localparam int unsigned IDX_TRIP = 0;
  localparam int unsigned IDX_SW   = 1;

  typedef logic [FLAG_N-1:0] flag_vec_t;

  function automatic int unsigned cyc_from_hz(input int unsigned hz,
                                              input int unsigned div);
    return (hz / div == 0) ? 1 : hz / div;
  endfunction
endpackage

// File: rtl/pwrsup_flag_filter.sv
module pwrsup_flag_filter #(
  parameter int unsigned STABLE_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  output logic flag_o
);
  localparam int unsigned CW = (STABLE_CYC < 2) ? 1 : $clog2(STABLE_CYC);

  logic          s1_q, s2_q;
  logic          flag_q, flag_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= raw_i;
      s2_q <= s1_q;
    end
  end

  always_comb begin
    flag_d = flag_q;
    cnt_d  = cnt_q;
    if (s2_q == flag_q) begin
      cnt_d = '0;
    end else if (cnt_q == CW'(STABLE_CYC - 1)) begin
      flag_d = s2_q;
      cnt_d  = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      flag_q <= flag_d;
      cnt_q  <= cnt_d;
    end
  end

  assign flag_o = flag_q;

  // R2: an accepted value must be the value seen by the second flop
  a_r2_accept_matches_sync: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q != $past(flag_q)) |-> (flag_q == $past(s2_q)));
endmodule

// File: rtl/pwrsup_timer.sv
module pwrsup_timer #(
  parameter int unsigned LEN_CYC = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic done_o
);
  localparam int unsigned CW = (LEN_CYC < 2) ? 1 : $clog2(LEN_CYC + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          done_q, done_d;
  logic          cnt_en;

  assign cnt_en = run_i && !done_q;

  always_comb begin
    cnt_d  = cnt_q;
    done_d = done_q;
    if (!run_i) begin
      cnt_d  = '0;
      done_d = 1'b0;
    end else if (cnt_en) begin
      if (cnt_q == CW'(LEN_CYC - 1)) begin
        done_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  assign done_o = done_q;

  // R8: dropping the run request restarts the interval from zero
  a_r8_idle_restarts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (cnt_q == '0) && !done_q);
  // R4: a finished interval stays finished while supply stays valid
  a_r4_done_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && done_q) |=> done_q);
endmodule

// File: rtl/pwrsup_fresh_latch.sv
module pwrsup_fresh_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  output logic armed_o
);
  logic armed_q, armed_d;

  always_comb begin
    armed_d = armed_q;
    if (valid_i) armed_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else         armed_q <= armed_d;
  end

  assign armed_o = armed_q;

  // R9: backup arming is permanent
  a_r9_armed_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q |=> armed_q);
  // R10: arming needs an accepted valid supply
  a_r10_arm_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(armed_q) |-> $past(valid_i));
endmodule

// File: rtl/pwr_supervisor.sv
module pwr_supervisor #(
  parameter int unsigned CLK_HZ     = 1000000,
  parameter int unsigned STABLE_CYC = 4,
  parameter int unsigned RST_CYC    = pwrsup_pkg::cyc_from_hz(CLK_HZ, 5),
  parameter int unsigned REC_CYC    = pwrsup_pkg::cyc_from_hz(CLK_HZ, 8)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic vtrip_ok_i,
  input  logic vsw_ok_i,
  input  logic mem_ce_i,
  input  logic mem_we_i,
  input  logic mem_oe_i,
  output logic rst_pull_o,
  output logic wprot_o,
  output logic bat_conn_o,
  output logic arr_ce_o,
  output logic arr_we_o,
  output logic arr_oe_o
);
  import pwrsup_pkg::*;

  logic      rs1_q, rs2_q, rst_sn;
  flag_vec_t raw_vec, flt_vec;
  logic      trip_ok, sw_ok;
  logic      rst_done, rec_done, armed;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end
  assign rst_sn = rs2_q;

  assign raw_vec[IDX_TRIP] = vtrip_ok_i;
  assign raw_vec[IDX_SW]   = vsw_ok_i;

  for (genvar g = 0; g < FLAG_N; g++) begin : g_flt
    pwrsup_flag_filter #(.STABLE_CYC(STABLE_CYC)) u_flt (
      .clk_i (clk_i),
      .rst_ni(rst_sn),
      .raw_i (raw_vec[g]),
      .flag_o(flt_vec[g])
    );
  end

  assign trip_ok = flt_vec[IDX_TRIP];
  assign sw_ok   = flt_vec[IDX_SW];

  pwrsup_timer #(.LEN_CYC(RST_CYC)) u_rst_tmr (
    .clk_i (clk_i),
    .rst_ni(rst_sn),
    .run_i (trip_ok),
    .done_o(rst_done)
  );

  pwrsup_timer #(.LEN_CYC(REC_CYC)) u_rec_tmr (
    .clk_i (clk_i),
    .rst_ni(rst_sn),
    .run_i (trip_ok),
    .done_o(rec_done)
  );

  pwrsup_fresh_latch u_fresh (
    .clk_i  (clk_i),
    .rst_ni (rst_sn),
    .valid_i(trip_ok),
    .armed_o(armed)
  );

  assign rst_pull_o = !(trip_ok && rst_done);
  assign wprot_o    = !(trip_ok && rec_done);
  assign bat_conn_o = armed && !sw_ok;

  always_comb begin
    arr_ce_o = 1'b0;
    arr_we_o = 1'b0;
    arr_oe_o = 1'b0;
    if (!wprot_o) begin
      arr_ce_o = mem_ce_i;
      arr_we_o = mem_ce_i && mem_we_i;
      arr_oe_o = mem_ce_i && mem_oe_i && !mem_we_i;
    end
  end

  // R3: an accepted fault leaves no interval running into the next cycle
  a_r3_fault_clears: assert property (@(posedge clk_i) disable iff (!rst_sn)
    !trip_ok |=> !rst_done && !rec_done);
  // R4: reset release only follows at least two cycles of valid supply
  a_r4_release_needs_valid: assert property (@(posedge clk_i) disable iff (!rst_sn)
    $fell(rst_pull_o) |-> trip_ok && $past(trip_ok));
  // R5: protection release only follows at least two cycles of valid supply
  a_r5_unprotect_needs_valid: assert property (@(posedge clk_i) disable iff (!rst_sn)
    $fell(wprot_o) |-> trip_ok && $past(trip_ok));
endmodule

// File: tb/sim_pwr_supervisor.sv
module sim_pwr_supervisor;
  localparam int PERIOD = 10;
  localparam int S   = 3;
  localparam int RST = 40;
  localparam int REC = 25;
  localparam int ACC = S + 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vtrip = 1'b0, vsw = 1'b0;
  logic ce = 1'b0, we = 1'b0, oe = 1'b0;
  logic rst_pull, wprot, bat_conn, a_ce, a_we, a_oe;
  int checks = 0, fails = 0;
  bit finished = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  pwr_supervisor #(.CLK_HZ(1000), .STABLE_CYC(S), .RST_CYC(RST), .REC_CYC(REC)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .vtrip_ok_i(vtrip), .vsw_ok_i(vsw),
    .mem_ce_i(ce), .mem_we_i(we), .mem_oe_i(oe),
    .rst_pull_o(rst_pull), .wprot_o(wprot), .bat_conn_o(bat_conn),
    .arr_ce_o(a_ce), .arr_we_o(a_we), .arr_oe_o(a_oe));

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    #1;
    chk("R1 rst_pull", rst_pull, 1'b1);
    chk("R1 wprot", wprot, 1'b1);
    chk("R1 bat_conn", bat_conn, 1'b0);
    chk("R1 arr strobes", a_ce | a_we | a_oe, 1'b0);
  endtask

  task automatic t_fresh();
    @(negedge clk); vsw = 1'b0; vtrip = 1'b0;
    edges(ACC + 4);
    chk("R10 no backup before first power-up", bat_conn, 1'b0);
  endtask

  task automatic t_power_up();
    @(negedge clk); vsw = 1'b1; vtrip = 1'b1;
    ce = 1'b1; we = 1'b1; oe = 1'b0;
    edges(ACC + REC - 1);
    chk("R5 wprot held", wprot, 1'b1);
    chk("R6 write blocked", a_we, 1'b0);
    edges(1);
    chk("R5 wprot released", wprot, 1'b0);
    chk("R4 reset still held", rst_pull, 1'b1);
    edges(RST - REC - 1);
    chk("R4 reset held", rst_pull, 1'b1);
    edges(1);
    chk("R4 reset released", rst_pull, 1'b0);
  endtask

  task automatic t_gating();
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); ce = i[0]; we = i[1]; oe = i[2];
      #1;
      chk("R7 ce", a_ce, i[0]);
      chk("R7 we", a_we, i[0] & i[1]);
      chk("R7 oe", a_oe, i[0] & i[2] & ~i[1]);
    end
  endtask

  task automatic t_glitch();
    @(negedge clk); vtrip = 1'b0;
    repeat (S - 1) @(negedge clk);
    vtrip = 1'b1;
    for (int i = 0; i < S + 6; i++) begin
      edges(1);
      chk("R2 glitch ignored wprot", wprot, 1'b0);
      chk("R2 glitch ignored reset", rst_pull, 1'b0);
    end
  endtask

  task automatic t_fault();
    @(negedge clk); vtrip = 1'b0;
    edges(ACC - 1);
    chk("R2 not yet accepted", wprot, 1'b0);
    edges(1);
    chk("R3 wprot on fault", wprot, 1'b1);
    chk("R3 reset on fault", rst_pull, 1'b1);
    chk("R6 strobes off", a_ce, 1'b0);
    @(negedge clk); vsw = 1'b0;
    edges(ACC);
    chk("R9 backup connects", bat_conn, 1'b1);
  endtask

  task automatic t_restart();
    @(negedge clk); vsw = 1'b1; vtrip = 1'b1;
    edges(ACC);
    chk("R9 backup disconnects", bat_conn, 1'b0);
    edges(REC - 5);
    @(negedge clk); vtrip = 1'b0;
    edges(ACC);
    chk("R8 reasserted wprot", wprot, 1'b1);
    @(negedge clk); vtrip = 1'b1;
    edges(ACC + REC - 1);
    chk("R8 full recovery retimed", wprot, 1'b1);
    edges(1);
    chk("R8 recovery ends", wprot, 1'b0);
    edges(RST - REC - 1);
    chk("R8 full reset retimed", rst_pull, 1'b1);
    edges(1);
    chk("R8 reset ends", rst_pull, 1'b0);
  endtask

  initial begin
    t_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_fresh();
    t_power_up();
    t_gating();
    t_glitch();
    t_fault();
    t_restart();
    finished = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(PERIOD * 100000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule